// File: doc/BRIEF.md
# Serial Memory Status and Write-Guard Unit

This unit sits behind the serial front end of a 2 KB serial memory that also carries a supervisor function. The front end has already shifted in and recognised each instruction. The unit receives the result as a one-cycle strobe with a small opcode and, for status writes, a data byte.

The unit keeps two volatile bits: a write-enable latch and a general-purpose flag. It also keeps a set of bits that stand in for nonvolatile storage and are modelled as plain registers: a two-bit lock level, a two-bit watchdog period select and a guard-enable bit. It combines the guard-enable bit with an active-low hardware write-protect pin, which gives a lockout for status writes.

For every array write the front end presents, the unit answers with a one-cycle grant or reject pulse. A granted write or an accepted status write starts an internal write cycle of a fixed, parameterised length, and `busy` is high for that whole cycle. The status byte is always visible for reads.

Top module: `spi_stat_guard`

## Requirements
- R1: After reset `status_byte` is 0x00, and `busy`, `arr_wr_grant` and `arr_wr_reject` are 0.
- R2: When idle, opcode 1 sets the write-enable latch and opcode 2 clears it. The latch is bit 1 of `status_byte` and is visible from the cycle after the strobe.
- R3: When idle, opcode 4 sets the flag and opcode 5 clears it. The flag is bit 0 of `status_byte`.
- R4: The lock level is status bits 3:2. Level 00 protects nothing, 01 protects 0x600–0x7FF, 10 protects 0x400–0x7FF and 11 protects the whole array. A write request to a protected address gets a reject pulse one cycle later and does not start a write cycle.
- R5: An array write request while the write-enable latch is 0 gets a reject pulse one cycle later and does not start a write cycle.
- R6: An accepted array write gets a grant pulse one cycle after the request. `busy` is then high for exactly WR_CYCLES cycles, and the write-enable latch reads 0 once `busy` falls.
- R7: Opcode 3 with the write-enable latch set starts a write cycle. When the cycle ends, data bits 7, 5:4 and 3:2 become status bits 7 (guard enable), 5:4 (watchdog select) and 3:2 (lock level), and the latch clears. Status bit 6 always reads 0. Status bits 7:2 never change at any other time.
- R8: If the guard-enable bit is 1 and `wp_n_pin` is 0 when opcode 3 arrives, the status write is refused. No write cycle starts, and the status byte, including the latch, is unchanged.
- R9: A status write cycle that has already started completes and commits its data even if `wp_n_pin` falls during the cycle.
- R10: While `busy` is high, all instruction strobes and array write requests are ignored, and neither a grant nor a reject pulse is produced.
- R11: An array write request in the same cycle as an instruction strobe is ignored, and no grant or reject pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | One-cycle strobe for a decoded instruction |
| cmd_op | input | 3 | Opcode: 1 latch set, 2 latch clear, 3 status write, 4 flag set, 5 flag clear |
| cmd_data | input | 8 | Status write data |
| wp_n_pin | input | 1 | Hardware write-protect pin, active low |
| arr_wr_req | input | 1 | Array write request strobe |
| arr_wr_addr | input | ADDR_W | Array write address |
| status_byte | output | 8 | Status byte for reads |
| busy | output | 1 | Internal write cycle in progress |
| arr_wr_grant | output | 1 | Array write accepted (pulse) |
| arr_wr_reject | output | 1 | Array write refused (pulse) |

## Verification
The assertions check several rules on every cycle:
- a grant and a reject pulse never occur together;
- a grant is always matched by a rising `busy` and needed the latch set one cycle before;
- requests seen while busy produce no response;
- status bits 7:2 move only on the edge where `busy` falls;
- the latch reads 0 right after a cycle ends.

Only the bench's scenarios can show the rest. That covers the exact address boundaries of each lock level and the refusal of a status write under an active guard with the pin low. It also covers a write cycle that survives the pin falling midway, the ignored request that collides with an instruction, and the exact length of the write cycle.

// File: rtl/spg_pkg.sv
// Package: opcode encoding and the nonvolatile field bundle shared by the
// status/guard unit and its bench. Assumes a 3-bit decoded opcode.
package spg_pkg;
    typedef enum logic [2:0] {
        OP_NONE       = 3'd0,
        OP_LATCH_SET  = 3'd1,
        OP_LATCH_CLR  = 3'd2,
        OP_STAT_WRITE = 3'd3,
        OP_FLAG_SET   = 3'd4,
        OP_FLAG_CLR   = 3'd5
    } spg_op_e;

    typedef struct packed {
        logic       guard_en;
        logic [1:0] wdog_sel;
        logic [1:0] lock_lvl;
    } spg_nv_t;
endpackage

// File: rtl/spg_cmd_decode.sv
// Turns the decoded-instruction strobe into one-hot action strobes.
// Assumes the front end holds cmd_op valid with cmd_valid; strobes are
// suppressed while a write cycle runs.
module spg_cmd_decode
    import spg_pkg::*;
(
    input  logic       cmd_valid,
    input  logic [2:0] cmd_op,
    input  logic       busy,
    output logic       latch_set,
    output logic       latch_clr,
    output logic       stat_wr,
    output logic       flag_set,
    output logic       flag_clr
);
    logic take;
    spg_op_e op;

    // Decode the opcode into action strobes, gated by idle.
    always_comb begin
        take      = cmd_valid && !busy;
        op        = spg_op_e'(cmd_op);
        latch_set = take && (op == OP_LATCH_SET);
        latch_clr = take && (op == OP_LATCH_CLR);
        stat_wr   = take && (op == OP_STAT_WRITE);
        flag_set  = take && (op == OP_FLAG_SET);
        flag_clr  = take && (op == OP_FLAG_CLR);
    end
endmodule

// File: rtl/spg_prot_map.sv
// Maps the two-bit lock level onto a protected address range: none,
// top quarter, top half, all. Assumes ADDR_W >= 2; purely combinational.
module spg_prot_map #(
    parameter int ADDR_W = 11
) (
    input  logic [1:0]        lock_lvl,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam int TOP = ADDR_W - 1;

    logic in_top_quarter;
    logic in_top_half;

    // Select the protection region from the lock level.
    always_comb begin
        in_top_half    = addr[TOP];
        in_top_quarter = addr[TOP] && addr[TOP-1];
        case (lock_lvl)
            2'b00:   hit = 1'b0;
            2'b01:   hit = in_top_quarter;
            2'b10:   hit = in_top_half;
            default: hit = 1'b1;
        endcase
    end
endmodule

// File: rtl/spg_wr_timer.sv
// Internal write-cycle timer: busy stays high for exactly CYCLES clocks
// after a start. The last_cyc output marks the final busy cycle.
// Assumes CYCLES >= 1 and that start is raised only while idle.
module spg_wr_timer #(
    parameter int CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic last_cyc
);
    localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    // Count down the remaining cycles of a running write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (busy) begin
            if (cnt == '0) begin
                busy <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= LOAD;
        end
    end

    // Flag the final cycle of the write.
    always_comb last_cyc = busy && (cnt == '0);
endmodule

// File: rtl/spi_stat_guard.sv
// Status register and write-protection unit for a serial memory.
// It holds the volatile latch and flag, models the nonvolatile fields
// as registers, applies the write-protect pin lockout at acceptance
// time, and grants or rejects array writes.
// Assumes strobes are single-cycle, and that the array write address is
// valid together with arr_wr_req.
module spi_stat_guard
    import spg_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int WR_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [7:0]        cmd_data,
    input  logic              wp_n_pin,
    input  logic              arr_wr_req,
    input  logic [ADDR_W-1:0] arr_wr_addr,
    output logic [7:0]        status_byte,
    output logic              busy,
    output logic              arr_wr_grant,
    output logic              arr_wr_reject
);
    logic    latch_set, latch_clr, stat_wr, flag_set, flag_clr;
    logic    wel, flag;
    spg_nv_t nv, pend_nv;
    logic    pend_is_stat;
    logic    prot_hit, last_cyc;
    logic    guard_lock, stat_ok, arr_try, arr_ok, start;

    spg_cmd_decode u_dec (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .busy      (busy),
        .latch_set (latch_set),
        .latch_clr (latch_clr),
        .stat_wr   (stat_wr),
        .flag_set  (flag_set),
        .flag_clr  (flag_clr)
    );

    spg_prot_map #(.ADDR_W(ADDR_W)) u_map (
        .lock_lvl (nv.lock_lvl),
        .addr     (arr_wr_addr),
        .hit      (prot_hit)
    );

    spg_wr_timer #(.CYCLES(WR_CYCLES)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .busy     (busy),
        .last_cyc (last_cyc)
    );

    // Decide which writes are accepted in this cycle.
    always_comb begin
        guard_lock = nv.guard_en && !wp_n_pin;
        stat_ok    = stat_wr && wel && !guard_lock;
        arr_try    = arr_wr_req && !cmd_valid && !busy;
        arr_ok     = arr_try && wel && !prot_hit;
        start      = stat_ok || arr_ok;
    end

    // Track the write-enable latch; a finishing write clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)         wel <= 1'b0;
        else if (last_cyc)  wel <= 1'b0;
        else if (latch_set) wel <= 1'b1;
        else if (latch_clr) wel <= 1'b0;
    end

    // Track the general-purpose flag.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag <= 1'b0;
        else if (flag_set) flag <= 1'b1;
        else if (flag_clr) flag <= 1'b0;
    end

    // Capture pending status data when a write cycle is launched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_nv      <= '0;
            pend_is_stat <= 1'b0;
        end else if (start) begin
            pend_is_stat <= stat_ok;
            pend_nv      <= '{guard_en: cmd_data[7],
                              wdog_sel: cmd_data[5:4],
                              lock_lvl: cmd_data[3:2]};
        end
    end

    // Commit the modelled nonvolatile fields at the end of a status write.
    always_ff @(posedge clk) begin
        if (!rst_n)                         nv <= '0;
        else if (last_cyc && pend_is_stat) nv <= pend_nv;
    end

    // Register the per-request grant and reject pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arr_wr_grant  <= 1'b0;
            arr_wr_reject <= 1'b0;
        end else begin
            arr_wr_grant  <= arr_ok;
            arr_wr_reject <= arr_try && !arr_ok;
        end
    end

    // Assemble the readable status byte.
    always_comb status_byte = {nv.guard_en, 1'b0, nv.wdog_sel, nv.lock_lvl, wel, flag};
endmodule

// File: rtl/spi_stat_guard_checker.sv
// Assertion checker for spi_stat_guard, attached by bind below.
// Observes the top-level ports only.
module spi_stat_guard_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] status_byte,
    input logic       busy,
    input logic       arr_wr_grant,
    input logic       arr_wr_reject
);
    AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(arr_wr_grant && arr_wr_reject)); // R4

    AST_GRANT_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr_grant |-> (busy && !$past(busy))); // R6

    AST_GRANT_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr_grant |-> $past(status_byte[1])); // R5

    AST_LATCH_CLEARED_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !status_byte[1]); // R6

    AST_NV_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(busy) |-> $stable(status_byte[7:2])); // R7

    AST_SILENT_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!arr_wr_grant && !arr_wr_reject)); // R10
endmodule

bind spi_stat_guard spi_stat_guard_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .status_byte   (status_byte),
    .busy          (busy),
    .arr_wr_grant  (arr_wr_grant),
    .arr_wr_reject (arr_wr_reject)
);

// File: tb/spi_stat_guard_tb_top.sv
// Bench: directed corner cases followed by seeded random traffic,
// checked each cycle against a reference model written from the
// requirements.
module spi_stat_guard_tb_top;
    import spg_pkg::*;

    localparam int AW = 11;
    localparam int WC = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = 3'd0;
    logic [7:0]    cmd_data = 8'd0;
    logic          wp_n_pin = 1'b1;
    logic          arr_wr_req = 1'b0;
    logic [AW-1:0] arr_wr_addr = '0;
    logic [7:0]    status_byte;
    logic          busy, arr_wr_grant, arr_wr_reject;

    int checks = 0;
    int errors = 0;

    // Reference model state
    logic       m_wel, m_flag, m_pe, m_busy, m_pstat, m_grant, m_rej;
    logic [1:0] m_wd, m_bl;
    logic [7:0] m_pend;
    int         m_cnt;

    always #10 clk = ~clk;

    spi_stat_guard #(.ADDR_W(AW), .WR_CYCLES(WC)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .wp_n_pin(wp_n_pin), .arr_wr_req(arr_wr_req),
        .arr_wr_addr(arr_wr_addr), .status_byte(status_byte), .busy(busy),
        .arr_wr_grant(arr_wr_grant), .arr_wr_reject(arr_wr_reject)
    );

    function automatic logic ref_prot(input logic [1:0] bl, input logic [AW-1:0] a);
        case (bl)
            2'b00:   return 1'b0;
            2'b01:   return a >= 11'h600;
            2'b10:   return a >= 11'h400;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [7:0] ref_status();
        return {m_pe, 1'b0, m_wd, m_bl, m_wel, m_flag};
    endfunction

    task automatic model_reset();
        m_wel = 0; m_flag = 0; m_pe = 0; m_busy = 0; m_pstat = 0;
        m_grant = 0; m_rej = 0; m_wd = 0; m_bl = 0; m_pend = 0; m_cnt = 0;
    endtask

    // Advance the model by one clock using the inputs currently driven.
    task automatic model_step();
        m_grant = 0; m_rej = 0;
        if (m_busy) begin
            if (m_cnt == 0) begin
                m_busy = 0; m_wel = 0;
                if (m_pstat) begin
                    m_pe = m_pend[7]; m_wd = m_pend[5:4]; m_bl = m_pend[3:2];
                end
            end else m_cnt--;
        end else if (cmd_valid) begin
            case (cmd_op)
                3'd1: m_wel = 1;
                3'd2: m_wel = 0;
                3'd3: if (m_wel && !(m_pe && !wp_n_pin)) begin
                          m_busy = 1; m_cnt = WC - 1; m_pend = cmd_data; m_pstat = 1;
                      end
                3'd4: m_flag = 1;
                3'd5: m_flag = 0;
                default: ;
            endcase
        end else if (arr_wr_req) begin
            if (m_wel && !ref_prot(m_bl, arr_wr_addr)) begin
                m_grant = 1; m_busy = 1; m_cnt = WC - 1; m_pstat = 0;
            end else m_rej = 1;
        end
    endtask

    task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        chk(tag, "status", status_byte, ref_status());
        chk(tag, "busy", {7'd0, busy}, {7'd0, m_busy});
        chk(tag, "grant", {7'd0, arr_wr_grant}, {7'd0, m_grant});
        chk(tag, "reject", {7'd0, arr_wr_reject}, {7'd0, m_rej});
    endtask

    // One cycle: drive at negedge, step model at posedge, compare at next negedge.
    task automatic step(input logic cv, input logic [2:0] op, input logic [7:0] d,
                        input logic wp, input logic rq, input logic [AW-1:0] a,
                        input string tag);
        cmd_valid = cv; cmd_op = op; cmd_data = d; wp_n_pin = wp;
        arr_wr_req = rq; arr_wr_addr = a;
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle(input int n, input logic wp, input string tag);
        for (int i = 0; i < n; i++) step(0, 3'd0, 8'd0, wp, 0, '0, tag);
    endtask

    task automatic cmd(input logic [2:0] op, input logic [7:0] d, input logic wp, input string tag);
        step(1, op, d, wp, 0, '0, tag);
    endtask

    task automatic awr(input logic [AW-1:0] a, input string tag);
        step(0, 3'd0, 8'd0, 1'b1, 1, a, tag);
    endtask

    initial begin
        #3000000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED1234));
        model_reset();
        repeat (3) @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
        // R5: write without the latch is rejected
        awr(11'h010, "R5");
        idle(1, 1, "R5");
        // R2: latch set and clear
        cmd(3'd1, 0, 1, "R2");
        cmd(3'd2, 0, 1, "R2");
        // R3: flag set and clear
        cmd(3'd4, 0, 1, "R3");
        cmd(3'd5, 0, 1, "R3");
        cmd(3'd4, 0, 1, "R3");
        // R7: status write commits 0xFF as 0xBC plus flag
        cmd(3'd1, 0, 1, "R7");
        cmd(3'd3, 8'hFF, 1, "R7");
        idle(WC + 1, 1, "R7");
        // R8: guard on, pin low -> refused, latch kept
        cmd(3'd1, 0, 0, "R8");
        cmd(3'd3, 8'h00, 0, "R8");
        idle(2, 0, "R8");
        // Pin high: write lock level 01, guard off
        cmd(3'd3, 8'h04, 1, "R7");
        idle(WC + 1, 1, "R7");
        // R4: level 01 boundaries
        cmd(3'd1, 0, 1, "R4");
        awr(11'h5FF, "R6");
        idle(WC + 1, 1, "R6");
        cmd(3'd1, 0, 1, "R4");
        awr(11'h600, "R4");
        awr(11'h7FF, "R4");
        // Level 10
        cmd(3'd3, 8'h08, 1, "R7");
        idle(WC + 1, 1, "R7");
        cmd(3'd1, 0, 1, "R4");
        awr(11'h400, "R4");
        awr(11'h3FF, "R4");
        idle(WC + 1, 1, "R4");
        // Level 11
        cmd(3'd1, 0, 1, "R4");
        cmd(3'd3, 8'h0C, 1, "R4");
        idle(WC + 1, 1, "R4");
        cmd(3'd1, 0, 1, "R4");
        awr(11'h000, "R4");
        // R9: pin falls mid-cycle, write completes, later refused
        cmd(3'd3, 8'h80, 1, "R9");
        idle(1, 1, "R9");
        idle(WC, 0, "R9");
        cmd(3'd1, 0, 0, "R9");
        cmd(3'd3, 8'h00, 0, "R9");
        idle(1, 0, "R9");
        // R10: commands and requests ignored while busy
        cmd(3'd3, 8'h00, 1, "R10");
        cmd(3'd1, 0, 1, "R10");
        cmd(3'd5, 0, 1, "R10");
        awr(11'h001, "R10");
        idle(WC, 1, "R10");
        // R11: request colliding with an instruction is ignored
        cmd(3'd1, 0, 1, "R11");
        step(1, 3'd4, 0, 1, 1, 11'h002, "R11");
        idle(1, 1, "R11");
        // Random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            logic cv, rq, wp;
            cv = ($urandom_range(0, 2) == 0);
            rq = ($urandom_range(0, 2) == 0);
            wp = ($urandom_range(0, 3) != 0);
            step(cv, 3'($urandom_range(0, 5)), 8'($urandom), wp, rq,
                 AW'($urandom), "R10");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule